// File: doc/BRIEF.md
# Three-Operand Integer Execute Unit

This block is the single-cycle execute stage of a small load-store integer core. It holds a 32-entry, 32-bit register file with two combinational read ports and one clocked write port, and an ALU that carries out register-register arithmetic and logic, immediate forms, and logical shifts by a constant amount. Each operation names two sources and one destination. The result goes to the destination on the rising clock edge.

Operations arrive already decoded as a 4-bit operation code. The surrounding pipeline supplies the register indices, a 16-bit immediate and a 5-bit shift amount, and asserts a write enable when the result should be kept. The ALU result leaves the block combinationally in the same cycle. A register's contents can be observed by issuing an OR of that register with register 0 and the write enable low.

Top module: `exu_core`

## Requirements
- R1: While the synchronous active-low reset is low at a rising edge, every register is cleared. After reset, every register reads 0.
- R2: Register index 0 always reads 0, even after a write to index 0 has been attempted.
- R3: Code 0 (ADD) gives src1+src2 and code 1 (SUB) gives src1−src2. Both wrap modulo 2^32 and have no overflow indication.
- R4: Code 2 (AND), code 3 (OR), code 4 (NOR, the complement of OR) and code 5 (XOR) act bitwise on src1 and src2.
- R5: Code 6 (SLL) shifts src1 toward the MSB by the shift amount and fills the low bits with zeros. Code 7 (SRL) shifts src1 toward the LSB and fills the high bits with zeros.
- R6: Code 8 (ADDI) adds src1 and the sign-extended immediate, which covers −32768 to 32767, with wrap-around.
- R7: Code 9 (ANDI), code 10 (ORI) and code 11 (XORI) combine src1 with the zero-extended immediate. For example, ORI of 0x09C35D9C with 0x0FFF gives 0x09C35FFF.
- R8: A register changes only at a rising edge where the write enable is high and the code is defined. With the write enable low, the destination keeps its value.
- R9: Codes 12 to 15 are undefined. They drive the result to 0 and write no register, even with the write enable high.
- R10: A result written at one edge is the source value of the next cycle. Summing 1 through 9 in a register loop gives 45, and the loop counter ends at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| wr_en | input | 1 | Keep this cycle's result in the destination register |
| op_code | input | 4 | Decoded operation code (0–11 defined) |
| dst_idx | input | 5 | Destination register index |
| src1_idx | input | 5 | First source register index |
| src2_idx | input | 5 | Second source register index |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Shift amount for SLL/SRL |
| result | output | 32 | Combinational ALU result |

## Verification
The bench targets operand order in SUB, where a swapped design returns the negated difference. It also covers sign versus zero extension: a design that extends the wrong way gives a wrong upper half for ADDI with a negative constant or for ANDI/ORI/XORI with bit 15 set. Further cases are writes to register 0, which a faulty design would let show up on later reads, and undefined codes or a low write enable, which must leave the destination as it was. Shift edges at amounts 0 and 31 would expose a sign fill or a wrong direction. The summation loop would expose any write that lands a cycle late.

// File: rtl/exu_pkg.sv
// Package: shared sizes and operation codes for the execute unit.
// Assumes operation codes are produced by an upstream decoder.
package exu_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int IDXW = $clog2(NREG);
    localparam int IMMW = 16;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_ADDI = 4'd8,
        OP_ANDI = 4'd9,
        OP_ORI  = 4'd10,
        OP_XORI = 4'd11
    } exu_op_e;
endpackage

// File: rtl/exu_regfile.sv
// Module: register file with two combinational read ports and one write port.
// Assumes: entry 0 is hard-wired to zero; the write happens on the rising edge;
// the synchronous active-low reset clears every entry.
module exu_regfile #(
    parameter int DW = 32,
    parameter int NR = 32,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2
);
    logic [DW-1:0] entry [NR];

    for (genvar g = 0; g < NR; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign entry[g] = '0;
        end else begin : g_reg
            logic [DW-1:0] q;
            // Hold or update one register entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && wa == AW'(g))
                    q <= wd;
            end
            assign entry[g] = q;
        end
    end

    // Combinational read of both source entries.
    always_comb begin
        rd1 = entry[ra1];
        rd2 = entry[ra2];
    end
endmodule

// File: rtl/exu_imm_ext.sv
// Module: widens the 16-bit immediate according to the operation.
// Assumes: only ADDI sign-extends; every other operation zero-extends.
module exu_imm_ext
    import exu_pkg::*;
#(
    parameter int IW = IMMW,
    parameter int OW = XLEN
) (
    input  exu_op_e        op,
    input  logic [IW-1:0]  imm,
    output logic [OW-1:0]  imm_x
);
    // Choose sign or zero extension.
    always_comb begin
        if (op == OP_ADDI)
            imm_x = {{(OW-IW){imm[IW-1]}}, imm};
        else
            imm_x = {{(OW-IW){1'b0}}, imm};
    end
endmodule

// File: rtl/exu_alu.sv
// Module: integer ALU for register and immediate forms plus logical shifts.
// Assumes: arithmetic wraps without overflow; undefined codes give zero
// and are flagged as not legal.
module exu_alu
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int SW = $clog2(W)
) (
    input  exu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  imm_x,
    input  logic [SW-1:0] sh,
    output logic [W-1:0]  y,
    output logic          legal
);
    // Select the operation result.
    always_comb begin
        legal = 1'b1;
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << sh;
            OP_SRL:  y = a >> sh;
            OP_ADDI: y = a + imm_x;
            OP_ANDI: y = a & imm_x;
            OP_ORI:  y = a | imm_x;
            OP_XORI: y = a ^ imm_x;
            default: begin
                y     = '0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exu_core.sv
// Module: top of the single-cycle execute stage: register file, immediate
// widening and ALU, with write-back of the result on the rising edge.
// Assumes: inputs are stable before the edge; reads are combinational.
module exu_core
    import exu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       op_code,
    input  logic [IDXW-1:0]  dst_idx,
    input  logic [IDXW-1:0]  src1_idx,
    input  logic [IDXW-1:0]  src2_idx,
    input  logic [IMMW-1:0]  imm16,
    input  logic [SHW-1:0]   shamt,
    output logic [XLEN-1:0]  result
);
    exu_op_e         op;
    logic [XLEN-1:0] a_val, b_val, imm_x, alu_y;
    logic            op_legal;
    logic            wr_fire;

    assign op      = exu_op_e'(op_code);
    assign wr_fire = wr_en & op_legal;
    assign result  = alu_y;

    exu_regfile #(.DW(XLEN), .NR(NREG)) u_rf (
        .clk (clk),
        .rst_n (rst_n),
        .we  (wr_fire),
        .wa  (dst_idx),
        .wd  (alu_y),
        .ra1 (src1_idx),
        .ra2 (src2_idx),
        .rd1 (a_val),
        .rd2 (b_val)
    );

    exu_imm_ext #(.IW(IMMW), .OW(XLEN)) u_ext (
        .op    (op),
        .imm   (imm16),
        .imm_x (imm_x)
    );

    exu_alu #(.W(XLEN)) u_alu (
        .op    (op),
        .a     (a_val),
        .b     (b_val),
        .imm_x (imm_x),
        .sh    (shamt),
        .y     (alu_y),
        .legal (op_legal)
    );
endmodule

// File: rtl/exu_core_chk.sv
// Module: property checker for the execute unit, bound to exu_core.
// Assumes: observes ports and the internal write strobe only.
module exu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_code,
    input logic [4:0]  dst_idx,
    input logic [4:0]  src1_idx,
    input logic [4:0]  src2_idx,
    input logic [15:0] imm16,
    input logic [4:0]  shamt,
    input logic [31:0] result,
    input logic        wr_fire
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && op_code == 4'd3 && src2_idx == 5'd0) |-> result == 32'd0);

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 && src1_idx == 5'd0 && src2_idx == 5'd0) |-> result == 32'd0);

    assert_sub_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1 && src1_idx == src2_idx) |-> result == 32'd0);

    assert_nor_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd4 && src1_idx == 5'd0 && src2_idx == 5'd0) |-> result == 32'hFFFF_FFFF);

    assert_xor_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd5 && src1_idx == src2_idx) |-> result == 32'd0);

    assert_sll_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd6) |-> (result & ((32'd1 << shamt) - 32'd1)) == 32'd0);

    assert_srl_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd7) |-> (result & ~(32'hFFFF_FFFF >> shamt)) == 32'd0);

    assert_addi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd8 && src1_idx == 5'd0) |-> result == {{16{imm16[15]}}, imm16});

    assert_andi_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9) |-> result[31:16] == 16'd0);

    assert_write_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_fire) && $past(dst_idx) != 5'd0 && op_code == 4'd3 &&
         src1_idx == $past(dst_idx) && src2_idx == 5'd0) |-> result == $past(result));

    assert_undef_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd12) |-> (result == 32'd0 && !wr_fire));
endmodule

bind exu_core exu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .dst_idx  (dst_idx),
    .src1_idx (src1_idx),
    .src2_idx (src2_idx),
    .imm16    (imm16),
    .shamt    (shamt),
    .result   (result),
    .wr_fire  (wr_fire)
);

// File: tb/tb_exu_core.sv
`timescale 1ns/1ps
// Bench: directed tests for exu_core, one task per scenario, with a shadow
// register model built from the requirements.
module tb_exu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [4:0]  dst_idx = '0, src1_idx = '0, src2_idx = '0, shamt = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] shadow [32];
    logic [31:0] last;

    exu_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_code(op_code),
        .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
        .imm16(imm16), .shamt(shamt), .result(result)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic [4:0] sh);
        logic [31:0] sx, zx;
        sx = {{16{im[15]}}, im};
        zx = {16'd0, im};
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return ~(a | b);
            4'd5:  return a ^ b;
            4'd6:  return a << sh;
            4'd7:  return a >> sh;
            4'd8:  return a + sx;
            4'd9:  return a & zx;
            4'd10: return a | zx;
            4'd11: return a ^ zx;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [4:0] d, input logic [4:0] s1,
                       input logic [4:0] s2, input logic [15:0] im, input logic [4:0] sh,
                       input bit we, input string tag);
        logic [31:0] e;
        @(negedge clk);
        op_code = op; dst_idx = d; src1_idx = s1; src2_idx = s2;
        imm16 = im; shamt = sh; wr_en = we;
        #1;
        e = model(op, shadow[s1], shadow[s2], im, sh);
        chk(tag, result, e);
        last = result;
        @(posedge clk);
        if (we && op < 4'd12 && d != 5'd0) shadow[d] = e;
        #0.5 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, input string tag);
        run(4'd3, 5'd0, idx, 5'd0, 16'd0, 5'd0, 1'b0, tag);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) shadow[i] = 32'd0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) rd(5'(i), "R1 reset clear");
    endtask

    task automatic t_zero_reg;
        run(4'd8, 5'd0, 5'd0, 5'd0, 16'h1234, 5'd0, 1'b1, "R2 write r0");
        rd(5'd0, "R2 r0 reads zero");
        chk("R2 r0 constant", last, 32'd0);
    endtask

    task automatic t_imm;
        run(4'd8, 5'd1, 5'd0, 5'd0, 16'h8000, 5'd0, 1'b1, "R6 addi min");
        chk("R6 addi -32768", last, 32'hFFFF_8000);
        run(4'd8, 5'd2, 5'd0, 5'd0, 16'h7FFF, 5'd0, 1'b1, "R6 addi max");
        chk("R6 addi 32767", last, 32'h0000_7FFF);
        run(4'd8, 5'd2, 5'd2, 5'd0, 16'hFFFF, 5'd0, 1'b1, "R6 addi -1");
        run(4'd10, 5'd3, 5'd0, 5'd0, 16'h09C3, 5'd0, 1'b1, "R7 ori hi");
        run(4'd6, 5'd3, 5'd3, 5'd0, 16'd0, 5'd16, 1'b1, "R5 sll 16");
        run(4'd10, 5'd3, 5'd3, 5'd0, 16'h5D9C, 5'd0, 1'b1, "R7 ori lo");
        chk("R7 built word", last, 32'h09C3_5D9C);
        run(4'd10, 5'd4, 5'd3, 5'd0, 16'h0FFF, 5'd0, 1'b1, "R7 ori fff");
        chk("R7 ori example", last, 32'h09C3_5FFF);
        run(4'd9, 5'd5, 5'd1, 5'd0, 16'hF0F0, 5'd0, 1'b1, "R7 andi zext");
        chk("R7 andi upper zero", last, 32'h0000_8000 & 32'h0000_F0F0);
        run(4'd11, 5'd6, 5'd1, 5'd0, 16'hFFFF, 5'd0, 1'b1, "R7 xori zext");
        chk("R7 xori value", last, 32'hFFFF_7FFF);
    endtask

    task automatic t_arith;
        run(4'd1, 5'd7, 5'd2, 5'd3, 16'd0, 5'd0, 1'b1, "R3 sub order");
        run(4'd1, 5'd8, 5'd3, 5'd2, 16'd0, 5'd0, 1'b1, "R3 sub swapped");
        run(4'd0, 5'd9, 5'd1, 5'd1, 16'd0, 5'd0, 1'b1, "R3 add wrap");
        chk("R3 wrap value", last, 32'hFFFF_0000);
        run(4'd1, 5'd10, 5'd0, 5'd2, 16'd0, 5'd0, 1'b1, "R3 sub negative");
    endtask

    task automatic t_logic;
        run(4'd2, 5'd11, 5'd3, 5'd6, 16'd0, 5'd0, 1'b1, "R4 and");
        run(4'd3, 5'd12, 5'd3, 5'd1, 16'd0, 5'd0, 1'b1, "R4 or");
        run(4'd4, 5'd13, 5'd3, 5'd0, 16'd0, 5'd0, 1'b1, "R4 nor as not");
        chk("R4 not value", last, 32'hF63C_A263);
        run(4'd5, 5'd14, 5'd3, 5'd4, 16'd0, 5'd0, 1'b1, "R4 xor");
        chk("R4 xor value", last, 32'h0000_0263);
    endtask

    task automatic t_shift;
        run(4'd6, 5'd15, 5'd3, 5'd0, 16'd0, 5'd0, 1'b1, "R5 sll 0");
        run(4'd6, 5'd15, 5'd3, 5'd0, 16'd0, 5'd4, 1'b1, "R5 sll 4");
        chk("R5 sll value", last, 32'h9C35_D9C0);
        run(4'd7, 5'd16, 5'd1, 5'd0, 16'd0, 5'd31, 1'b1, "R5 srl 31 zero fill");
        chk("R5 srl value", last, 32'd1);
        run(4'd6, 5'd17, 5'd2, 5'd0, 16'd0, 5'd31, 1'b1, "R5 sll 31");
    endtask

    task automatic t_write_gate;
        run(4'd0, 5'd3, 5'd1, 5'd1, 16'd0, 5'd0, 1'b0, "R8 no-enable op");
        rd(5'd3, "R8 dest kept");
        chk("R8 dest value", last, 32'h09C3_5D9C);
        run(4'd13, 5'd3, 5'd1, 5'd2, 16'h00FF, 5'd3, 1'b1, "R9 undefined result");
        chk("R9 zero result", last, 32'd0);
        rd(5'd3, "R9 dest kept");
        chk("R9 dest value", last, 32'h09C3_5D9C);
        run(4'd15, 5'd4, 5'd4, 5'd4, 16'hFFFF, 5'd1, 1'b1, "R9 code 15");
        rd(5'd4, "R9 code 15 dest kept");
    endtask

    task automatic t_loop;
        run(4'd8, 5'd20, 5'd0, 5'd0, 16'd1, 5'd0, 1'b1, "R10 i=1");
        run(4'd0, 5'd21, 5'd0, 5'd0, 16'd0, 5'd0, 1'b1, "R10 res=0");
        for (int it = 0; it < 20; it++) begin
            run(4'd0, 5'd21, 5'd21, 5'd20, 16'd0, 5'd0, 1'b1, "R10 res+=i");
            run(4'd8, 5'd20, 5'd20, 5'd0, 16'd1, 5'd0, 1'b1, "R10 i++");
            if (last >= 32'd10) break;
        end
        rd(5'd21, "R10 res read");
        chk("R10 sum is 45", last, 32'd45);
        rd(5'd20, "R10 counter read");
        chk("R10 counter is 10", last, 32'd10);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_zero_reg();
        t_imm();
        t_arith();
        t_logic();
        t_shift();
        t_write_gate();
        t_loop();
        finish_run();
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule